// File: doc/BRIEF.md
# Configuration Boot and Reset Sequencer

This block brings a multi-channel clock device out of power-up and handles every later reset. When the power-on reset is released, or after any hard reset, it reads a parameterized number of configuration words from a non-volatile store. The store is modelled as a synchronous ROM with one cycle of read latency. Each word goes into the register file at the same index. Until the last word is written, the serial interface is held off (`serialReady` low), every channel is held in reset and every clock output is disabled.

A hard reset can come from the external reset pin, which is synchronized through two flops, or from a self-clearing register bit. It discards whatever is in progress, including a partial download and any soft-reset pulse, and starts the download again from word zero. A soft reset never touches the store. It applies only once the device is running. It drives a fixed-length reset pulse onto the channels selected by a mask and leaves the other channels untouched.

Top module: `bootSeqTop`

## Requirements
- R1: After power-on reset release, the block reads store words 0 to NUM_WORDS-1 on consecutive cycles. `romRdEn` is high with `romAddr` equal to the word index, and word 0 is read in the first cycle after release.
- R2: Each word is written one cycle after its read (`cfgWrEn` high). `cfgWrAddr` equals the word index and `cfgWrData` equals the value the store returned.
- R3: `serialReady` is low from reset until the cycle after the last word is written, and high from then on. With no reset in between, this is NUM_WORDS+1 cycles after release.
- R4: While `serialReady` is low, `clkOutEn` is all zeros and `chanRst` is all ones.
- R5: The reset pin (active low) is registered twice before use. While the synchronized pin is low, no read is issued. The download restarts at word 0 once the pin has been released.
- R6: A high `hardRstBit` is acknowledged in the same cycle on `hardRstClr`. In the next cycle `serialReady` is low and the download restarts at word 0.
- R7: A hard reset during a download or during a soft-reset pulse ends that activity at once: no write is made in the request cycle, all soft pulses clear, and every channel is held in reset again.
- R8: When `softRstBit` is high while running, each channel whose `softRstMask` bit is 1 has `chanRst` high and `clkOutEn` low for exactly SOFT_PULSE cycles, starting the next cycle. No store read or register write takes place.
- R9: Channels whose `softRstMask` bit is 0 keep `chanRst` low and `clkOutEn` high during a soft reset.
- R10: `softRstClr` is high in a cycle only when `softRstBit` is high, the block is running and no hard reset is pending. A soft request during a download has no effect.
- R11: A soft reset on a channel whose pulse is still running restarts that channel's count at SOFT_PULSE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstPinN | input | 1 | External hard-reset pin, active low, asynchronous |
| hardRstBit | input | 1 | Hard-reset register bit |
| hardRstClr | output | 1 | Clears the hard-reset bit |
| softRstBit | input | 1 | Soft-reset register bit |
| softRstMask | input | NUM_CH | Channels targeted by a soft reset |
| softRstClr | output | 1 | Clears the soft-reset bit |
| romRdEn | output | 1 | Store read strobe |
| romAddr | output | ADDR_W | Store read address |
| romData | input | DATA_W | Store data, valid one cycle after the read |
| cfgWrEn | output | 1 | Register-file write strobe |
| cfgWrAddr | output | ADDR_W | Register-file write address |
| cfgWrData | output | DATA_W | Register-file write data |
| serialReady | output | 1 | Serial interface may be used |
| clkOutEn | output | NUM_CH | Per-channel clock output enable |
| chanRst | output | NUM_CH | Per-channel logic reset |

## Verification
Read strobes and addresses, acknowledges and the ready and enable outputs are combinational from state and inputs. They are due in the same cycle as a request and settle one edge after the state changes. Writes follow their reads by one cycle, and a soft pulse starts the cycle after the request edge. The pin adds two cycles before it acts. The bench's reference model steps at each rising edge with the inputs held at that edge, and is compared against every output at the falling edge. Stimulus changes 1 ns after a rising edge, so each result is read half a period after the edge that produced it.

// File: rtl/bootSeqPkg.sv
package bootSeqPkg;

  typedef enum logic {
    ST_LOAD = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;    // hard reset: clear download and soft pulses
    logic issueRead;  // read next store word this cycle
    logic softApply;  // load pulse counters of masked channels
    logic running;    // initialization finished
  } seqStrobe_t;

endpackage

// File: rtl/bootSeqCtrl.sv
module bootSeqCtrl
  import bootSeqPkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       pinSyncN,
  input  logic       hardRstBit,
  input  logic       softRstBit,
  input  logic       moreToIssue,
  input  logic       lastWrite,
  output seqStrobe_t strobe,
  output logic       hardRstClr,
  output logic       softRstClr
);

  seqState_t state;
  seqState_t stateNext;
  logic      hardReq;

  assign hardReq = !pinSyncN || hardRstBit;

  always_comb begin
    stateNext = state;
    if (hardReq) begin
      stateNext = ST_LOAD;
    end else if (state == ST_LOAD && lastWrite) begin
      stateNext = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state <= ST_LOAD;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    strobe.restart   = hardReq;
    strobe.issueRead = (state == ST_LOAD) && !hardReq && moreToIssue;
    strobe.softApply = (state == ST_RUN) && !hardReq && softRstBit;
    strobe.running   = (state == ST_RUN);
  end

  assign hardRstClr = hardRstBit;
  assign softRstClr = strobe.softApply;

  // R3
  no_read_running_chk: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_RUN) |-> !strobe.issueRead);

  // R5
  pin_blocks_read_chk: assert property (@(posedge clk) disable iff (!porN)
    !pinSyncN |-> !strobe.issueRead);

endmodule

// File: rtl/bootSeqData.sv
module bootSeqData
  import bootSeqPkg::*;
#(
  parameter int NUM_WORDS  = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_CH     = 4,
  parameter int SOFT_PULSE = 6,
  parameter int ADDR_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstPinN,
  input  seqStrobe_t        strobe,
  input  logic [NUM_CH-1:0] softRstMask,
  input  logic [DATA_W-1:0] romData,
  output logic              pinSyncN,
  output logic              moreToIssue,
  output logic              lastWrite,
  output logic              romRdEn,
  output logic [ADDR_W-1:0] romAddr,
  output logic              cfgWrEn,
  output logic [ADDR_W-1:0] cfgWrAddr,
  output logic [DATA_W-1:0] cfgWrData,
  output logic [NUM_CH-1:0] clkOutEn,
  output logic [NUM_CH-1:0] chanRst
);

  localparam int              PULSE_W   = $clog2(SOFT_PULSE + 1);
  localparam logic [ADDR_W:0] WORD_CNT  = (ADDR_W + 1)'(NUM_WORDS);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);
  localparam logic [PULSE_W-1:0] PULSE_LD = PULSE_W'(SOFT_PULSE);

  // two-flop synchronizer for the reset pin
  logic pinMeta;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pinMeta  <= 1'b1;
      pinSyncN <= 1'b1;
    end else begin
      pinMeta  <= rstPinN;
      pinSyncN <= pinMeta;
    end
  end

  // download counter and one-cycle read pipeline
  logic [ADDR_W:0]   issueCnt;
  logic              rdValid;
  logic [ADDR_W-1:0] lastAddr;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      issueCnt <= '0;
      rdValid  <= 1'b0;
      lastAddr <= '0;
    end else if (strobe.restart) begin
      issueCnt <= '0;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= strobe.issueRead;
      if (strobe.issueRead) begin
        lastAddr <= issueCnt[ADDR_W-1:0];
        issueCnt <= issueCnt + 1'b1;
      end
    end
  end

  assign moreToIssue = (issueCnt < WORD_CNT);
  assign romRdEn     = strobe.issueRead;
  assign romAddr     = issueCnt[ADDR_W-1:0];
  assign cfgWrEn     = rdValid && !strobe.restart;
  assign cfgWrAddr   = lastAddr;
  assign cfgWrData   = romData;
  assign lastWrite   = cfgWrEn && (lastAddr == LAST_IDX);

  // per-channel soft-reset pulse counters
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [PULSE_W-1:0] pulseCnt;

    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        pulseCnt <= '0;
      end else if (strobe.restart) begin
        pulseCnt <= '0;
      end else if (strobe.softApply && softRstMask[ch]) begin
        pulseCnt <= PULSE_LD;
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - 1'b1;
      end
    end

    assign chanRst[ch]  = !strobe.running || (pulseCnt != '0);
    assign clkOutEn[ch] = strobe.running && (pulseCnt == '0);

    // R9
    unmasked_quiet_chk: assert property (@(posedge clk) disable iff (!porN)
      (strobe.running && !chanRst[ch] && !strobe.restart && !softRstMask[ch])
        |=> !chanRst[ch]);
  end

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!porN)
    (romRdEn && $past(romRdEn) && $past(porN))
      |-> romAddr == ADDR_W'($past(romAddr) + 1'b1));

  // R2
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!porN)
    (romRdEn && !strobe.restart) |=> (strobe.restart || (cfgWrEn && cfgWrAddr == $past(romAddr))));

endmodule

// File: rtl/bootSeqTop.sv
module bootSeqTop
  import bootSeqPkg::*;
#(
  parameter int NUM_WORDS  = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_CH     = 4,
  parameter int SOFT_PULSE = 6,
  parameter int ADDR_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstPinN,
  input  logic              hardRstBit,
  output logic              hardRstClr,
  input  logic              softRstBit,
  input  logic [NUM_CH-1:0] softRstMask,
  output logic              softRstClr,
  output logic              romRdEn,
  output logic [ADDR_W-1:0] romAddr,
  input  logic [DATA_W-1:0] romData,
  output logic              cfgWrEn,
  output logic [ADDR_W-1:0] cfgWrAddr,
  output logic [DATA_W-1:0] cfgWrData,
  output logic              serialReady,
  output logic [NUM_CH-1:0] clkOutEn,
  output logic [NUM_CH-1:0] chanRst
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);

  seqStrobe_t strobe;
  logic       pinSyncN;
  logic       moreToIssue;
  logic       lastWrite;

  bootSeqCtrl u_ctrl (
    .clk         (clk),
    .porN        (porN),
    .pinSyncN    (pinSyncN),
    .hardRstBit  (hardRstBit),
    .softRstBit  (softRstBit),
    .moreToIssue (moreToIssue),
    .lastWrite   (lastWrite),
    .strobe      (strobe),
    .hardRstClr  (hardRstClr),
    .softRstClr  (softRstClr)
  );

  bootSeqData #(
    .NUM_WORDS  (NUM_WORDS),
    .DATA_W     (DATA_W),
    .NUM_CH     (NUM_CH),
    .SOFT_PULSE (SOFT_PULSE),
    .ADDR_W     (ADDR_W)
  ) u_data (
    .clk         (clk),
    .porN        (porN),
    .rstPinN     (rstPinN),
    .strobe      (strobe),
    .softRstMask (softRstMask),
    .romData     (romData),
    .pinSyncN    (pinSyncN),
    .moreToIssue (moreToIssue),
    .lastWrite   (lastWrite),
    .romRdEn     (romRdEn),
    .romAddr     (romAddr),
    .cfgWrEn     (cfgWrEn),
    .cfgWrAddr   (cfgWrAddr),
    .cfgWrData   (cfgWrData),
    .clkOutEn    (clkOutEn),
    .chanRst     (chanRst)
  );

  assign serialReady = strobe.running;

  // R4
  no_early_clock_chk: assert property (@(posedge clk) disable iff (!porN)
    !serialReady |-> (clkOutEn == '0 && chanRst == '1));

  // R6
  hard_bit_restart_chk: assert property (@(posedge clk) disable iff (!porN)
    hardRstBit |=> (!serialReady && romAddr == '0));

  // R8
  rst_excludes_en_chk: assert property (@(posedge clk) disable iff (!porN)
    (chanRst & clkOutEn) == '0);

  // R3
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!porN)
    $rose(serialReady) |-> ($past(cfgWrEn) && $past(cfgWrAddr) == LAST_IDX));

endmodule

// File: tb/bootSeqTop_tb.sv
module bootSeqTop_tb;

  localparam int N      = 16;
  localparam int DW     = 8;
  localparam int NCH    = 4;
  localparam int PULSE  = 6;
  localparam int AW     = $clog2(N);

  logic           clk = 1'b0;
  logic           porN;
  logic           rstPinN = 1'b1;
  logic           hardRstBit = 1'b0;
  logic           hardRstClr;
  logic           softRstBit = 1'b0;
  logic [NCH-1:0] softRstMask = '0;
  logic           softRstClr;
  logic           romRdEn;
  logic [AW-1:0]  romAddr;
  logic [DW-1:0]  romData = '0;
  logic           cfgWrEn;
  logic [AW-1:0]  cfgWrAddr;
  logic [DW-1:0]  cfgWrData;
  logic           serialReady;
  logic [NCH-1:0] clkOutEn;
  logic [NCH-1:0] chanRst;

  int testsRun = 0;
  int testsFailed = 0;
  int cycleCnt = 0;

  always #2.5 clk = ~clk;

  bootSeqTop #(.NUM_WORDS(N), .DATA_W(DW), .NUM_CH(NCH), .SOFT_PULSE(PULSE)) u_dut (
    .clk(clk), .porN(porN), .rstPinN(rstPinN),
    .hardRstBit(hardRstBit), .hardRstClr(hardRstClr),
    .softRstBit(softRstBit), .softRstMask(softRstMask), .softRstClr(softRstClr),
    .romRdEn(romRdEn), .romAddr(romAddr), .romData(romData),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .serialReady(serialReady), .clkOutEn(clkOutEn), .chanRst(chanRst)
  );

  function automatic logic [DW-1:0] romFn(int a);
    return DW'(a * 37 + 5);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // store model with one cycle of latency, and shadow register file
  logic [DW-1:0] shadow [N];
  always @(posedge clk) begin
    if (romRdEn) romData <= romFn(int'(romAddr));
    if (cfgWrEn) shadow[cfgWrAddr] <= cfgWrData;
  end

  // behavioural reference model
  int mMode = 0;
  int mIssue = 0;
  int mRdV = 0;
  int mLast = 0;
  int s1 = 1, s2 = 1;
  int mCnt [NCH] = '{default: 0};

  function automatic bit hreqNow();
    return (s2 == 0) || hardRstBit;
  endfunction

  always @(posedge clk) begin
    if (!porN) begin
      mMode = 0; mIssue = 0; mRdV = 0; mLast = 0; s1 = 1; s2 = 1;
      foreach (mCnt[c]) mCnt[c] = 0;
    end else begin
      automatic bit hr = hreqNow();
      automatic int oIssue = mIssue;
      automatic int oRdV = mRdV;
      automatic int oLast = mLast;
      if (hr) begin
        mMode = 0; mIssue = 0; mRdV = 0;
        foreach (mCnt[c]) mCnt[c] = 0;
      end else if (mMode == 0) begin
        mRdV = (oIssue < N) ? 1 : 0;
        if (oIssue < N) begin
          mLast = oIssue;
          mIssue = oIssue + 1;
        end
        if (oRdV == 1 && oLast == N - 1) mMode = 1;
      end else begin
        mRdV = 0;
        foreach (mCnt[c]) begin
          if (softRstBit && softRstMask[c]) mCnt[c] = PULSE;
          else if (mCnt[c] > 0) mCnt[c] = mCnt[c] - 1;
        end
      end
      s2 = s1;
      s1 = rstPinN ? 1 : 0;
    end
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    automatic bit hr = hreqNow();
    automatic bit eRd = (mMode == 0) && (mIssue < N) && !hr;
    automatic bit eWr = (mRdV == 1) && !hr;
    automatic logic [NCH-1:0] eEn, eRst;
    for (int c = 0; c < NCH; c++) begin
      eEn[c]  = (mMode == 1) && (mCnt[c] == 0);
      eRst[c] = (mMode == 0) || (mCnt[c] != 0);
    end
    check(romRdEn == eRd, "R1 romRdEn", romRdEn, eRd);
    if (eRd) check(int'(romAddr) == mIssue, "R1 romAddr", romAddr, mIssue);
    check(cfgWrEn == eWr, "R2 cfgWrEn", cfgWrEn, eWr);
    if (eWr) begin
      check(int'(cfgWrAddr) == mLast, "R2 cfgWrAddr", cfgWrAddr, mLast);
      check(cfgWrData == romFn(mLast), "R2 cfgWrData", cfgWrData, romFn(mLast));
    end
    check(serialReady == (mMode == 1), "R3 serialReady", serialReady, mMode);
    check(clkOutEn == eEn, "R4/R8/R9 clkOutEn", clkOutEn, eEn);
    check(chanRst == eRst, "R4/R8/R9 chanRst", chanRst, eRst);
    check(hardRstClr == hardRstBit, "R6 hardRstClr", hardRstClr, hardRstBit);
    check(softRstClr == (softRstBit && mMode == 1 && !hr), "R10 softRstClr",
          softRstClr, softRstBit && mMode == 1 && !hr);
  end

  // watchdog
  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 100000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=done", cycleCnt);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  // pulse window counters
  bit countEn = 1'b0;
  int highCnt [NCH];
  always @(negedge clk) begin
    if (countEn) for (int c = 0; c < NCH; c++) if (chanRst[c]) highCnt[c]++;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic softPulse(logic [NCH-1:0] m, output bit ackSeen);
    softRstBit = 1'b1;
    softRstMask = m;
    @(negedge clk);
    ackSeen = softRstClr;
    @(posedge clk);
    #1;
    softRstBit = 1'b0;
  endtask

  task automatic hardPulse();
    hardRstBit = 1'b1;
    @(posedge clk);
    #1;
    hardRstBit = 1'b0;
  endtask

  task automatic waitReady();
    int guard = 0;
    while (!serialReady && guard < 1000) begin
      tick(1);
      guard++;
    end
  endtask

  initial begin
    bit ack;
    int readyAt;
    porN = 1'b0;
    tick(4);
    @(negedge clk);
    // R3 R4 reset state
    check(serialReady == 1'b0, "R3 reset ready", serialReady, 0);
    check(clkOutEn == '0 && chanRst == '1, "R4 reset outputs", {clkOutEn, chanRst}, 8'h0f);
    @(posedge clk);
    #1;
    porN = 1'b1;
    readyAt = 0;
    while (!serialReady && readyAt < 1000) begin
      tick(1);
      readyAt++;
    end
    // R3 ready after N+1 cycles
    check(readyAt == N + 1, "R3 load time", readyAt, N + 1);
    tick(1);
    // R2 register file content
    for (int i = 0; i < N; i++)
      check(shadow[i] == romFn(i), "R2 shadow", shadow[i], romFn(i));

    // R8 R9 soft reset on channels 0 and 2
    foreach (highCnt[c]) highCnt[c] = 0;
    countEn = 1'b1;
    softPulse(4'b0101, ack);
    tick(PULSE + 3);
    countEn = 1'b0;
    check(ack == 1'b1, "R10 soft ack running", ack, 1);
    check(highCnt[0] == PULSE, "R8 ch0 pulse len", highCnt[0], PULSE);
    check(highCnt[2] == PULSE, "R8 ch2 pulse len", highCnt[2], PULSE);
    check(highCnt[1] == 0 && highCnt[3] == 0, "R9 unmasked", highCnt[1] + highCnt[3], 0);

    // R11 retrigger one cycle into the pulse
    foreach (highCnt[c]) highCnt[c] = 0;
    countEn = 1'b1;
    softPulse(4'b0001, ack);
    softPulse(4'b0001, ack);
    tick(PULSE + 3);
    countEn = 1'b0;
    check(highCnt[0] == PULSE + 1, "R11 retrigger len", highCnt[0], PULSE + 1);

    // R7 hard bit during soft pulse; R6 acknowledge
    softPulse(4'b1111, ack);
    tick(2);
    hardPulse();
    @(negedge clk);
    check(romRdEn && romAddr == '0, "R7 restart word0", romAddr, 0);
    check(chanRst == '1 && !serialReady, "R6 held after hard", chanRst, 4'hf);

    // R10 soft request during download is ignored
    tick(3);
    softPulse(4'b1111, ack);
    check(ack == 1'b0, "R10 soft ack in load", ack, 0);
    // R7 hard bit mid download restarts
    tick(3);
    hardPulse();
    readyAt = 0;
    while (!serialReady && readyAt < 1000) begin
      tick(1);
      readyAt++;
    end
    check(readyAt == N + 1, "R7 reload time", readyAt, N + 1);

    // R5 pin low while running
    rstPinN = 1'b0;
    tick(5);
    @(negedge clk);
    check(!serialReady && !romRdEn, "R5 pin held", {serialReady, romRdEn}, 0);
    @(posedge clk);
    #1;
    rstPinN = 1'b1;
    tick(6);
    rstPinN = 1'b0;
    tick(1);
    rstPinN = 1'b1;
    waitReady();
    tick(2);
    check(serialReady == 1'b1, "R5 ready after pin", serialReady, 1);
    for (int i = 0; i < N; i++)
      check(shadow[i] == romFn(i), "R2 shadow final", shadow[i], romFn(i));

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule